// File: doc/BRIEF.md
# Serial Video Scrambler and NRZI Line Encoder

This block sits in the serial domain of a high-definition video transmitter. It takes one bit per serial clock. First it whitens the stream with a self-synchronizing scrambler built on the polynomial X^9 + X^4 + 1. It then turns the scrambled bits into a transition-coded (NRZI) line signal using the polynomial X + 1. Because the scrambler is self-synchronizing, a receiver can recover the data without any shared seed. The NRZI stage makes the received signal insensitive to polarity.

A bypass control lets pre-coded streams, such as data that is already scrambled or 8b/10b symbols, pass straight to the output. A clear control empties both stages. A clock enable qualifies every serial cycle, so the block can run from a fast clock at a lower bit rate. The output is registered, and the delay from input to output is one enabled cycle in every mode.

Top module: `video_scr_nrzi`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output, the 9-bit scrambler history and the NRZI level all become 0. The first normal bits after reset are therefore encoded as if from a cleared state.
- R2: In normal mode (`bypass` = 0), the scrambled bit is s(n) = d(n) XOR s(n-4) XOR s(n-9). Here s(k) is the scrambled bit of the k-th earlier enabled normal cycle, and the history holds zeros after a clear or reset.
- R3: In normal mode, the NRZI level inverts when s(n) = 1 and holds when s(n) = 0. `dout` shows the new level.
- R4: On an enabled cycle, `dout` changes at the same clock edge that samples `din`. The delay is one cycle in both normal and bypass mode.
- R5: With `bypass` = 1 and `ce` = 1, `dout` equals the `din` sampled at that edge.
- R6: Bypass cycles leave the scrambler history and the NRZI level untouched. When normal mode resumes, encoding continues as if the bypassed bits had never arrived.
- R7: With `clr` = 1 at a clock edge, the history, the NRZI level and `dout` all become 0, whatever `ce` and `bypass` are.
- R8: With `ce` = 0 and `clr` = 0, `dout`, the history and the NRZI level all hold their values.
- R9: A receiver that NRZI-decodes `dout` and then descrambles it with the same polynomial recovers the original `din` sequence exactly, when both start from cleared state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous active-high clear of both coding stages |
| ce | input | 1 | Clock enable; one serial bit per enabled cycle |
| bypass | input | 1 | 1: pass `din` through unchanged; 0: scramble and NRZI-encode |
| din | input | 1 | Serial data in |
| dout | output | 1 | Registered serial data out |

## Verification
The bench mixes bypass bursts into normal traffic. A design that shifted its history during bypass would drift away from the model on the first normal bit afterwards. Stalls through `ce` are placed both alone and in the middle of bypass runs, to catch a design that advances or changes its output on idle cycles. A clear is applied while `ce` is low, which exposes a clear wrongly gated by the enable. A long loopback run through an independent NRZI decoder and descrambler exposes a swapped tap, a wrong polynomial order or an inverted NRZI sense, because the recovered data would no longer match the input.

// File: rtl/vscr_pkg.sv
// Package: shared constants for the serial scrambler / NRZI encoder.
// Assumes a single tap pair plus the end of the history register.
package vscr_pkg;
    localparam int unsigned SCR_ORDER = 9;
    localparam int unsigned SCR_TAP   = 4;
endpackage

// File: rtl/vscr_scrambler.sv
// Self-synchronizing scrambler: s = d ^ s[n-TAP] ^ s[n-ORDER].
// Assumes TAP < ORDER. The history shifts only when adv is high, and
// clears on reset or clr.
module vscr_scrambler #(
    parameter int unsigned ORDER = vscr_pkg::SCR_ORDER,
    parameter int unsigned TAP   = vscr_pkg::SCR_TAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             din,
    output logic             scr_bit,
    output logic [ORDER-1:0] state
);
    logic [ORDER-1:0] st_q;
    logic [ORDER-1:0] st_d;

    // Feedback: newest history bit is index 0, oldest is ORDER-1.
    assign scr_bit = din ^ st_q[TAP-1] ^ st_q[ORDER-1];

    // Next-history wiring, one stage per bit.
    for (genvar i = 0; i < ORDER; i++) begin : g_shift
        if (i == 0) begin : g_head
            assign st_d[i] = scr_bit;
        end else begin : g_body
            assign st_d[i] = st_q[i-1];
        end
    end

    // History register: clear, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q <= '0;
        end else if (adv) begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/vscr_nrzi.sv
// NRZI (X + 1) stage: the held level inverts on a 1 and holds on a 0.
// Assumes the level changes only when adv is high.
module vscr_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic bit_in,
    output logic level_next,
    output logic level
);
    logic level_q;

    // Level that this cycle's bit produces.
    assign level_next = level_q ^ bit_in;

    // Level register: clear, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level_q <= 1'b0;
        end else if (adv) begin
            level_q <= level_next;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/video_scr_nrzi.sv
// Top: scrambler cascaded with the NRZI stage, plus a bypass mux in front
// of one output register. Assumes one bit per cycle where ce is high.
// Bypass freezes both stages. Latency is one enabled cycle in every mode.
module video_scr_nrzi #(
    parameter int unsigned ORDER = vscr_pkg::SCR_ORDER,
    parameter int unsigned TAP   = vscr_pkg::SCR_TAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ce,
    input  logic bypass,
    input  logic din,
    output logic dout
);
    logic             adv;
    logic             scr_bit;
    logic [ORDER-1:0] scr_state;
    logic             level_next;
    logic             level_q;
    logic             out_q;

    // Both coding stages move only on enabled normal-mode cycles.
    assign adv = ce & ~bypass;

    vscr_scrambler #(.ORDER(ORDER), .TAP(TAP)) u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .adv    (adv),
        .din    (din),
        .scr_bit(scr_bit),
        .state  (scr_state)
    );

    vscr_nrzi u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .adv       (adv),
        .bit_in    (scr_bit),
        .level_next(level_next),
        .level     (level_q)
    );

    // Output register: raw input in bypass, new NRZI level otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_q <= 1'b0;
        end else if (ce) begin
            out_q <= bypass ? din : level_next;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/vscr_chk.sv
// Checker for video_scr_nrzi. It watches the ports together with the
// history and level registers, and is attached to the top through bind.
module vscr_chk #(
    parameter int unsigned ORDER = vscr_pkg::SCR_ORDER
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             ce,
    input logic             bypass,
    input logic             din,
    input logic             dout,
    input logic             level,
    input logic [ORDER-1:0] state
);
    logic rst_seen_q;

    // Records whether reset was low at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            reset_clears_chk: assert (dout == 1'b0 && level == 1'b0 && state == '0)
                else $error("reset did not clear the block");
        end
    end

    // R2
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !bypass && !clr) |=> state[ORDER-1:1] == $past(state[ORDER-2:0]));

    // R3
    out_follows_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !bypass && !clr) |=> dout == level);

    // R5
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && bypass && !clr) |=> dout == $past(din));

    // R6
    bypass_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && bypass && !clr) |=> ($stable(state) && $stable(level)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dout == 1'b0 && level == 1'b0 && state == '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> ($stable(dout) && $stable(state) && $stable(level)));
endmodule

bind video_scr_nrzi vscr_chk #(.ORDER(ORDER)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .ce    (ce),
    .bypass(bypass),
    .din   (din),
    .dout  (dout),
    .level (level_q),
    .state (scr_state)
);

// File: tb/tb_video_scr_nrzi.sv
// Bench: a stimulus table checked against a behavioural model, then
// directed reset, latency and loopback tests.
module tb_video_scr_nrzi;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic ce = 1'b0;
    logic bypass = 1'b0;
    logic din = 1'b0;
    logic dout;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Model state
    logic [8:0] m_hist = '0;
    logic m_lvl = 1'b0;
    logic m_out = 1'b0;

    always #2.5 clk = ~clk;

    video_scr_nrzi dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ce(ce),
        .bypass(bypass), .din(din), .dout(dout)
    );

    // Entry bits: [3]=clr [2]=ce [1]=bypass [0]=din
    localparam logic [3:0] VEC [0:27] = '{
        4'b0101, 4'b0100, 4'b0101, 4'b0101, 4'b0100, 4'b0101,
        4'b0001, 4'b0000, 4'b0101, 4'b0111, 4'b0110, 4'b0011,
        4'b0111, 4'b0101, 4'b0100, 4'b0100, 4'b1101, 4'b0101,
        4'b0101, 4'b1001, 4'b0100, 4'b0101, 4'b0110, 4'b0111,
        4'b0101, 4'b0101, 4'b0100, 4'b0101
    };

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dout=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Model step for one edge with the given controls.
    task automatic model_step(input logic c, input logic e, input logic b, input logic d);
        logic s;
        if (c) begin
            m_hist = '0; m_lvl = 1'b0; m_out = 1'b0;
        end else if (e) begin
            if (b) begin
                m_out = d;
            end else begin
                s = d ^ m_hist[3] ^ m_hist[8];
                m_hist = {m_hist[7:0], s};
                m_lvl = m_lvl ^ s;
                m_out = m_lvl;
            end
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, then compare.
    task automatic cyc(input logic c, input logic e, input logic b, input logic d,
                       input string req);
        clr = c; ce = e; bypass = b; din = d;
        @(negedge clk);
        model_step(c, e, b, d);
        check(req, dout, m_out);
    endtask

    function automatic string tag_of(input logic [3:0] v);
        if (v[3]) return "R7";
        if (!v[2]) return "R8";
        if (v[1]) return "R5/R6";
        return "R2/R3";
    endfunction

    initial begin
        logic [31:0] lfsr;
        logic rx_prev;
        logic [8:0] rx_hist;
        logic sbit;
        logic rec;
        logic [511:0] sent;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", dout, 1'b0);
        rst_n = 1'b1;

        // Table walk against the model
        for (int i = 0; i < 28; i++) begin
            cyc(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], tag_of(VEC[i]));
        end

        // R7: clear while ce is low
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R2");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        check("R7", dout, 1'b0);

        // R4: latency of one cycle in normal mode, from a cleared state
        clr = 1'b0; ce = 1'b1; bypass = 1'b0; din = 1'b1;
        check("R4", dout, 1'b0);
        @(negedge clk);
        model_step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R4", dout, 1'b1);
        // R4: latency in bypass mode
        bypass = 1'b1; din = 1'b0;
        check("R4", dout, 1'b1);
        @(negedge clk);
        model_step(1'b0, 1'b1, 1'b1, 1'b0);
        check("R4", dout, 1'b0);

        // R6: long bypass burst, then normal mode resumes
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, 1'b1, 1'(i % 3 == 0), "R6");
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b0, 1'(i % 2), "R6");

        // R1: reset with dirty state, then check the encoding restarts fresh
        rst_n = 1'b0; ce = 1'b1; bypass = 1'b0; din = 1'b1;
        @(negedge clk);
        m_hist = '0; m_lvl = 1'b0; m_out = 1'b0;
        check("R1", dout, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b0, 1'(i < 3), "R1");

        // R9: loopback through an independent decoder
        cyc(1'b1, 1'b1, 1'b0, 1'b0, "R7");
        lfsr = 32'h1234_5678;
        rx_prev = 1'b0; rx_hist = '0;
        for (int i = 0; i < 512; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sent[i] = lfsr[0];
            cyc(1'b0, 1'b1, 1'b0, lfsr[0], "R2/R3");
            sbit = dout ^ rx_prev;
            rx_prev = dout;
            rec = sbit ^ rx_hist[3] ^ rx_hist[8];
            rx_hist = {rx_hist[7:0], sbit};
            check("R9", rec, sent[i]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: dout=%b expected=finish", dout);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule